// File: doc/BRIEF.md
# Camera Frame Grabber

This block takes one still frame from a parallel camera port and turns it into a stream of memory writes. The camera supplies a frame pulse, a line pulse, a pixel strobe, a line-valid level and a 16-bit sample bus. All of these are asynchronous to the system clock. They pass through two-flop synchronisers, and the three pulses are reduced to rising-edge events in the system domain. The system clock has to run at least four times faster than the pixel strobe. This covers both a full-speed sensor (about 74 ns per pixel) and a sensor slowed to a few microseconds per pixel.

Software requests a frame by pulsing `arm`. The block then waits for a frame pulse, which sets the line count to zero. Each line pulse that arrives while line-valid is high opens a new row. Each pixel strobe that arrives while line-valid is high stores one sample at the current row and the next column. Rows form the outer index and columns the inner index. Each write appears as a one-cycle strobe, with the column, row and sample presented alongside it. After the last pixel of the last row, `frame_done` rises. The block then ignores the camera until it is armed again.

Top module: `cam_frame_grabber`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `wr_en` and `frame_done` are 0; the block comes out of reset unarmed.
- R2: While unarmed, camera activity produces no write and leaves `frame_done` at 0.
- R3: After `arm`, line and pixel events are ignored until a frame pulse rising edge is seen.
- R4: A line pulse rising edge with line-valid high opens the next row, starting at row 0 after the frame pulse, and resets the column to 0. A line pulse with line-valid low opens no row.
- R5: A pixel strobe rising edge with line-valid high, inside an open row, writes one sample. A strobe with line-valid low writes nothing and does not advance the column.
- R6: Strobes beyond column WIDTH-1 within a row are ignored.
- R7: Each write is a single-cycle `wr_en` pulse. It carries `wr_x` (column), `wr_y` (row) and `wr_data`, which equals the sample present at the strobe edge. Columns within a row run 0, 1, 2, and so on.
- R8: `frame_done` rises in the same cycle as the write at column WIDTH-1 of row HEIGHT-1. It then stays high, and no further write occurs, whatever the camera does.
- R9: A frame pulse that arrives before the frame is complete restarts capture at row 0.
- R10: When a line pulse and a pixel strobe rise in the same system cycle with line-valid high, the line event is applied first. The sample is written as column 0 of the newly opened row.
- R11: `arm` clears `frame_done` in the following cycle and waits for a new frame pulse.
- R12: Camera levels held for two system cycles are detected correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle request to capture the next frame |
| cam_vsync | input | 1 | Frame pulse from camera (asynchronous) |
| cam_hsync | input | 1 | Line pulse from camera (asynchronous) |
| cam_pclk | input | 1 | Pixel strobe from camera (asynchronous) |
| cam_lval | input | 1 | Line-valid reference level (asynchronous) |
| cam_data | input | DATA_W | Pixel sample bus |
| wr_en | output | 1 | Memory write strobe, one cycle per sample |
| wr_x | output | $clog2(WIDTH) | Column of the sample |
| wr_y | output | $clog2(HEIGHT) | Row of the sample |
| wr_data | output | DATA_W | Captured sample |
| frame_done | output | 1 | Frame complete, held until re-armed |

## Verification
A line-open event and a pixel event can be detected in the same system cycle. In that case the row must advance first, and the sample must land at column 0 of the new row. The bench provokes this by raising the line pulse, the pixel strobe and line-valid at the same clock edge, in the middle of a frame. It judges the result against its queue of expected (row, column, sample) writes. The final write of the frame, which raises `frame_done` in the same cycle, is checked the same way. The bench also checks that traffic after completion leaves both outputs unchanged.

// File: rtl/cam_grab_pkg.sv
package cam_grab_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_LINES = 2'd2,
    ST_DONE  = 2'd3
  } grab_state_t;
endpackage

// File: rtl/cam_stage2.sv
// Two-flop synchroniser for a bus of independent levels.
module cam_stage2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      dout <= '0;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/cam_edge_sync.sv
// Synchronises N strobes and flags their rising edges.
module cam_edge_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl;
  logic [N-1:0] lvl_d;

  cam_stage2 #(.W(N)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .dout (lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= '0;
    else     lvl_d <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] = lvl[i] & ~lvl_d[i];
  end
endmodule

// File: rtl/cam_capture_ctrl.sv
// Frame/line/pixel sequencing and the registered write port.
module cam_capture_ctrl
  import cam_grab_pkg::*;
#(
  parameter int WIDTH  = 640,
  parameter int HEIGHT = 480,
  parameter int DATA_W = 16,
  localparam int XW  = (WIDTH  > 1) ? $clog2(WIDTH)  : 1,
  localparam int YW  = (HEIGHT > 1) ? $clog2(HEIGHT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              vs_rise,
  input  logic              hs_rise,
  input  logic              pc_rise,
  input  logic              lval,
  input  logic [DATA_W-1:0] data,
  output logic              wr_en,
  output logic [XW-1:0]     wr_x,
  output logic [YW-1:0]     wr_y,
  output logic [DATA_W-1:0] wr_data,
  output logic              frame_done
);
  localparam int XCW = $clog2(WIDTH + 1);
  localparam int YCW = $clog2(HEIGHT + 1);
  localparam logic [XCW-1:0] X_LIM  = XCW'(WIDTH);
  localparam logic [YCW-1:0] Y_LIM  = YCW'(HEIGHT);
  localparam logic [XCW-1:0] X_LAST = XCW'(WIDTH - 1);
  localparam logic [YW-1:0]  Y_LAST = YW'(HEIGHT - 1);

  grab_state_t     st, st_n;
  logic [YCW-1:0]  row_cnt, row_n;
  logic [XCW-1:0]  col_cnt, col_n;
  logic [YW-1:0]   cur_row, cur_n;
  logic            pix_en, pix_en_n;
  logic            do_wr;
  logic [XW-1:0]   wx;

  // Events within one cycle apply in order: frame, line, pixel.
  always_comb begin
    st_n     = st;
    row_n    = row_cnt;
    col_n    = col_cnt;
    cur_n    = cur_row;
    pix_en_n = pix_en;
    do_wr    = 1'b0;
    wx       = '0;
    if (arm) begin
      st_n     = ST_WAIT;
      row_n    = '0;
      col_n    = '0;
      pix_en_n = 1'b0;
    end else begin
      if (vs_rise && (st == ST_WAIT || st == ST_LINES)) begin
        st_n     = ST_LINES;
        row_n    = '0;
        pix_en_n = 1'b0;
      end
      if (st_n == ST_LINES && hs_rise && lval && row_n < Y_LIM) begin
        cur_n    = row_n[YW-1:0];
        row_n    = row_n + 1'b1;
        col_n    = '0;
        pix_en_n = 1'b1;
      end
      if (st_n == ST_LINES && pc_rise && lval && pix_en_n && col_n < X_LIM) begin
        do_wr = 1'b1;
        wx    = col_n[XW-1:0];
        if (col_n == X_LAST && cur_n == Y_LAST) st_n = ST_DONE;
        col_n = col_n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      row_cnt    <= '0;
      col_cnt    <= '0;
      cur_row    <= '0;
      pix_en     <= 1'b0;
      wr_en      <= 1'b0;
      wr_x       <= '0;
      wr_y       <= '0;
      wr_data    <= '0;
      frame_done <= 1'b0;
    end else begin
      st         <= st_n;
      row_cnt    <= row_n;
      col_cnt    <= col_n;
      cur_row    <= cur_n;
      pix_en     <= pix_en_n;
      wr_en      <= do_wr;
      frame_done <= (st_n == ST_DONE);
      if (do_wr) begin
        wr_x    <= wx;
        wr_y    <= cur_n;
        wr_data <= data;
      end
    end
  end
endmodule

// File: rtl/cam_frame_grabber.sv
module cam_frame_grabber #(
  parameter int WIDTH  = 640,
  parameter int HEIGHT = 480,
  parameter int DATA_W = 16,
  localparam int XW = (WIDTH  > 1) ? $clog2(WIDTH)  : 1,
  localparam int YW = (HEIGHT > 1) ? $clog2(HEIGHT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              cam_vsync,
  input  logic              cam_hsync,
  input  logic              cam_pclk,
  input  logic              cam_lval,
  input  logic [DATA_W-1:0] cam_data,
  output logic              wr_en,
  output logic [XW-1:0]     wr_x,
  output logic [YW-1:0]     wr_y,
  output logic [DATA_W-1:0] wr_data,
  output logic              frame_done
);
  logic [2:0]        rise;
  logic [DATA_W:0]   lvl_bus;

  // Strobes: bit 2 frame, bit 1 line, bit 0 pixel.
  cam_edge_sync #(.N(3)) u_edges (
    .clk  (clk),
    .rst  (rst),
    .din  ({cam_vsync, cam_hsync, cam_pclk}),
    .rise (rise)
  );

  // Levels share the strobes' synchroniser depth so they stay aligned.
  cam_stage2 #(.W(DATA_W + 1)) u_levels (
    .clk  (clk),
    .rst  (rst),
    .din  ({cam_lval, cam_data}),
    .dout (lvl_bus)
  );

  cam_capture_ctrl #(
    .WIDTH  (WIDTH),
    .HEIGHT (HEIGHT),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .vs_rise    (rise[2]),
    .hs_rise    (rise[1]),
    .pc_rise    (rise[0]),
    .lval       (lvl_bus[DATA_W]),
    .data       (lvl_bus[DATA_W-1:0]),
    .wr_en      (wr_en),
    .wr_x       (wr_x),
    .wr_y       (wr_y),
    .wr_data    (wr_data),
    .frame_done (frame_done)
  );
endmodule

// File: rtl/cam_frame_grabber_chk.sv
module cam_frame_grabber_chk #(
  parameter int WIDTH  = 640,
  parameter int HEIGHT = 480,
  localparam int XW = (WIDTH  > 1) ? $clog2(WIDTH)  : 1,
  localparam int YW = (HEIGHT > 1) ? $clog2(HEIGHT) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          arm,
  input logic          wr_en,
  input logic [XW-1:0] wr_x,
  input logic [YW-1:0] wr_y,
  input logic          frame_done
);
  logic [XW-1:0] prev_x;
  logic [YW-1:0] prev_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_x <= '0;
      prev_y <= '0;
    end else if (wr_en) begin
      prev_x <= wr_x;
      prev_y <= wr_y;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!wr_en && !frame_done));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  a_r7_column_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_x != '0) |-> (wr_x == prev_x + 1'b1 && wr_y == prev_y));

  a_r6_x_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_x <= XW'(WIDTH - 1) && wr_y <= YW'(HEIGHT - 1)));

  a_r8_done_on_last: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_done) |-> (wr_en && wr_x == XW'(WIDTH - 1) && wr_y == YW'(HEIGHT - 1)));

  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
    (frame_done && $past(frame_done)) |-> !wr_en);

  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    ($past(frame_done) && !$past(arm)) |-> frame_done);

  a_r11_arm_clears: assert property (@(posedge clk) disable iff (rst)
    $past(arm) |-> !frame_done);
endmodule

bind cam_frame_grabber cam_frame_grabber_chk #(
  .WIDTH  (WIDTH),
  .HEIGHT (HEIGHT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .arm        (arm),
  .wr_en      (wr_en),
  .wr_x       (wr_x),
  .wr_y       (wr_y),
  .frame_done (frame_done)
);

// File: tb/cam_frame_grabber_test.sv
`timescale 1ns/1ps
module cam_frame_grabber_test;
  localparam int W  = 4;
  localparam int H  = 3;
  localparam int DW = 16;
  localparam int XW = $clog2(W);
  localparam int YW = $clog2(H);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0;
  logic vs = 1'b0, hs = 1'b0, pc = 1'b0, lv = 1'b0;
  logic [DW-1:0] pd = '0;
  logic          wr_en;
  logic [XW-1:0] wr_x;
  logic [YW-1:0] wr_y;
  logic [DW-1:0] wr_data;
  logic          frame_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] expq[$];

  always #4 clk = ~clk;

  cam_frame_grabber #(.WIDTH(W), .HEIGHT(H), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .arm(arm),
    .cam_vsync(vs), .cam_hsync(hs), .cam_pclk(pc), .cam_lval(lv),
    .cam_data(pd),
    .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y), .wr_data(wr_data),
    .frame_done(frame_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] sample(input int seed, input int y, input int x);
    return DW'(seed * 256 + y * 16 + x);
  endfunction

  // Every observed write is compared with the head of the expected queue (R5, R7).
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      logic [31:0] got;
      got = {8'(wr_y), 8'(wr_x), wr_data};
      if (expq.size() == 0) begin
        check(1'b0, "R5 unexpected write", int'(got), 0);
      end else begin
        logic [31:0] exp;
        exp = expq.pop_front();
        check(got == exp, "R7 write {y,x,data}", int'(got), int'(exp));
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic vs_pulse();
    @(negedge clk); vs = 1'b1; wait_n(3); vs = 1'b0; wait_n(3);
  endtask

  task automatic hs_pulse(input logic lvl);
    @(negedge clk); hs = 1'b1; lv = lvl; wait_n(3); hs = 1'b0; wait_n(3);
  endtask

  task automatic px(input logic lvl, input logic [DW-1:0] d, input bit push,
                    input int y, input int x, input int hold);
    @(negedge clk); lv = lvl; pd = d; pc = 1'b1;
    if (push) expq.push_back({8'(y), 8'(x), d});
    wait_n(hold); pc = 1'b0; wait_n(hold);
  endtask

  // Line pulse and pixel strobe rise together (R10).
  task automatic combo(input logic [DW-1:0] d, input int y);
    @(negedge clk); hs = 1'b1; pc = 1'b1; lv = 1'b1; pd = d;
    expq.push_back({8'(y), 8'd0, d});
    wait_n(3); hs = 1'b0; pc = 1'b0; wait_n(3);
  endtask

  task automatic arm_pulse();
    @(negedge clk); arm = 1'b1; @(negedge clk); arm = 1'b0;
  endtask

  initial begin
    wait_n(5);
    check(wr_en == 1'b0 && frame_done == 1'b0, "R1 outputs in reset", int'({wr_en, frame_done}), 0);
    rst = 1'b0;
    wait_n(1);
    check(wr_en == 1'b0 && frame_done == 1'b0, "R1 outputs after reset", int'({wr_en, frame_done}), 0);

    // R2: unarmed, a full burst of camera traffic
    vs_pulse();
    hs_pulse(1'b1);
    for (int x = 0; x < W; x++) px(1'b1, sample(1, 0, x), 1'b0, 0, x, 3);
    wait_n(8);
    check(frame_done == 1'b0, "R2 done stays low while unarmed", int'(frame_done), 0);

    // R3: armed, but no frame pulse yet
    arm_pulse();
    hs_pulse(1'b1);
    for (int x = 0; x < 2; x++) px(1'b1, sample(2, 0, x), 1'b0, 0, x, 3);
    vs_pulse();
    // R4: line with line-valid low opens no row, so its strobes are dropped
    hs_pulse(1'b0);
    px(1'b1, sample(3, 9, 9), 1'b0, 0, 0, 3);

    for (int y = 0; y < H; y++) begin
      int hold;
      hold = (y == H - 1) ? 2 : 3;  // R12: last row uses 2-cycle levels
      hs_pulse(1'b1);
      for (int x = 0; x < W + 2; x++) begin
        if (y == 1 && x == 1) px(1'b0, sample(4, 7, 7), 1'b0, 0, 0, hold); // R5 gap
        px(1'b1, sample(4, y, x), x < W, y, x, hold); // R6 extras not pushed
        if (y == H - 1 && x == W - 1) begin
          wait_n(1);
          check(frame_done == 1'b1, "R8 done after last pixel", int'(frame_done), 1);
        end
      end
    end
    wait_n(5);
    check(expq.size() == 0, "R8 all frame writes seen", expq.size(), 0);

    // R8: traffic after completion is ignored
    vs_pulse();
    hs_pulse(1'b1);
    for (int x = 0; x < W; x++) px(1'b1, sample(5, 0, x), 1'b0, 0, x, 3);
    wait_n(5);
    check(frame_done == 1'b1, "R8 done holds", int'(frame_done), 1);

    // R11: re-arm
    arm_pulse();
    check(frame_done == 1'b0, "R11 arm clears done", int'(frame_done), 0);
    hs_pulse(1'b1);
    px(1'b1, sample(6, 0, 0), 1'b0, 0, 0, 3);

    // R9: partial frame, then a restart
    vs_pulse();
    hs_pulse(1'b1);
    for (int x = 0; x < 2; x++) px(1'b1, sample(7, 0, x), 1'b1, 0, x, 3);
    vs_pulse();
    hs_pulse(1'b1);
    for (int x = 0; x < W; x++) px(1'b1, sample(8, 0, x), 1'b1, 0, x, 3);
    check(frame_done == 1'b0, "R9 restart keeps done low", int'(frame_done), 0);
    // R10: row 1 opens with a coincident strobe
    combo(sample(8, 1, 0), 1);
    for (int x = 1; x < W; x++) px(1'b1, sample(8, 1, x), 1'b1, 1, x, 3);
    hs_pulse(1'b1);
    for (int x = 0; x < W; x++) px(1'b1, sample(8, 2, x), 1'b1, 2, x, 3);
    wait_n(5);
    check(frame_done == 1'b1, "R10 frame completes after coincident start", int'(frame_done), 1);
    check(expq.size() == 0, "R9 all restarted writes seen", expq.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule